// File: doc/BRIEF.md
# ATAPI Device Register and Command Packet Port

This block is the device end of a parallel ATA/ATAPI register interface. It runs on an internal clock. The host strobes are asynchronous to that clock, so the block passes them through a synchroniser first. The host picks a target with two active-low chip selects and a 3-bit address. It then pulses the I/O read or I/O write strobe. The block holds the task-file registers: sector count, LBA low, byte-count pair, device, features, command and device control. It also presents a status byte that firmware supplies.

While firmware holds the block in packet phase, 16-bit writes to the data port fill a 12-byte command packet store. When the store is full, a flag tells firmware a packet is waiting. Outside packet phase, data-port reads take 16-bit words from a first-word-fall-through buffer. If the buffer is empty, the block pulls the ready line low and holds the host cycle until a word arrives. The interrupt request line is enabled only when this device is addressed and interrupts are not disabled.

Top module: `atapi_regport`

## Requirements
- R1: The target of an access is decoded as follows.
  - With cs0_n=0 and cs1_n=1, the address selects: 0 data port, 1 error (read) or features (write), 2 sector count, 3 LBA low, 4 byte count low, 5 byte count high, 6 device, 7 status (read) or command (write).
  - With cs0_n=1 and cs1_n=0 and address 6, it selects alternate status (read) or device control (write).
  - Any other combination reads nothing (dd_oe stays 0) and writes nothing.
- R2: Register reads return the 8-bit value on dd_o[7:0] with dd_o[15:8]=0. Register writes use dd_i[7:0] only. Data-port transfers use all 16 bits. Sector count, LBA low, both byte-count registers and device read back the last value written.
- R3: Each strobe pulse performs exactly one access. The access happens when the synchronised strobe falls, however long the host holds the strobe low.
- R4: In packet phase (pkt_phase=1), each data-port write stores dd_i[7:0] and then dd_i[15:8] as the next two packet bytes. After the sixth write, pkt_ready goes to 1. It stays at 1 until a pkt_clear pulse, which also empties the store. pkt_idx=k presents stored byte k on pkt_byte.
- R5: A data-port write while the 12-byte store is full is ignored and leaves the stored bytes unchanged. It sets a sticky overflow flag, which reads as bit 0 of the error register.
- R6: intrq_oe is 1 only when device-control bit 1 (interrupt disable) is 0 and device-register bit 4 equals the DEV_ID parameter (default 0). intrq_o carries the pending interrupt.
- R7: A one-cycle irq_set pulse makes the interrupt pending. A status-register read clears it. An alternate-status read leaves it pending.
- R8: A data-port read outside packet phase returns the oldest buffer word and pops it with buf_pop. If the buffer is empty, iordy goes to 0 until a word becomes available. The word is then returned and iordy goes back to 1.
- R9: Writing device control with bit 2 set, or holding hrst_n low, does all of the following:
  - empties the packet store and clears pkt_ready, the overflow flag and the pending interrupt;
  - clears every task-file register to 0.
- R10: A command-register write places the byte on cmd_code and pulses cmd_stb for exactly one cycle.
- R11: Data-port writes while pkt_phase=0 do not enter the packet store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hrst_n | input | 1 | Host hardware reset, active low, asynchronous to clk |
| cs0_n | input | 1 | Command-block chip select, active low |
| cs1_n | input | 1 | Control-block chip select, active low |
| da | input | 3 | Register address |
| dior_n | input | 1 | Host I/O read strobe, active low |
| diow_n | input | 1 | Host I/O write strobe, active low |
| dd_i | input | 16 | Host data bus, inbound |
| dd_o | output | 16 | Host data bus, outbound |
| dd_oe | output | 1 | Drive enable for dd_o |
| iordy | output | 1 | Ready; 0 stretches the host cycle |
| intrq_o | output | 1 | Interrupt request value |
| intrq_oe | output | 1 | Interrupt pin drive enable (0 = high impedance) |
| fw_status | input | 8 | Status byte supplied by firmware |
| irq_set | input | 1 | Firmware pulse that makes an interrupt pending |
| pkt_phase | input | 1 | 1 = data-port writes fill the packet store |
| pkt_clear | input | 1 | Firmware pulse: empty the store and drop pkt_ready |
| pkt_ready | output | 1 | A complete packet is stored |
| pkt_idx | input | 4 | Packet byte index for firmware |
| pkt_byte | output | 8 | Packet byte at pkt_idx |
| buf_valid | input | 1 | Buffer word available |
| buf_data | input | 16 | Oldest buffer word |
| buf_pop | output | 1 | Consume the buffer word |
| cmd_code | output | 8 | Last command byte written |
| cmd_stb | output | 1 | One-cycle pulse on a command write |
| tf_features | output | 8 | Features register |
| tf_bytecnt | output | 16 | Byte count, high and low registers joined |

## Verification
Most faults in this block can be seen at the host pins within one access.

- A corrupted task-file register, or a broken decode, shows on the next read of that register as a wrong byte, or as dd_oe at the wrong level.
- A packet counter that drifts shows as pkt_ready rising one write early or late, or as bytes out of place when firmware reads them back by index.
- A strobe handled twice shows on the following data-port read, which returns a word that was skipped.
- An interrupt-pending bit that is wrong shows at once on intrq_o.
- A ready stall that never releases stops the host read loop, and the bench reports that as a failure.

// File: rtl/atapi_rp_pkg.sv
package atapi_rp_pkg;
  localparam int CTL_NIEN_BIT = 1;
  localparam int CTL_SRST_BIT = 2;
  localparam int DEV_SEL_BIT  = 4;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_ERRFEAT,
    SEL_COUNT,
    SEL_LBALO,
    SEL_BCLO,
    SEL_BCHI,
    SEL_DEV,
    SEL_STATCMD,
    SEL_ALTCTL
  } rp_sel_e;
endpackage

// File: rtl/atapi_rp_sync.sv
module atapi_rp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [STAGES-1:0][W-1:0] sh_q;
  logic [STAGES-1:0][W-1:0] sh_d;

  always_comb begin
    sh_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) sh_d[s] = sh_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/atapi_rp_decode.sv
module atapi_rp_decode
  import atapi_rp_pkg::*;
(
  input  logic       cs0_n,
  input  logic       cs1_n,
  input  logic [2:0] da,
  output rp_sel_e    sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (!cs0_n && cs1_n) begin
      case (da)
        3'd0:    sel_o = SEL_DATA;
        3'd1:    sel_o = SEL_ERRFEAT;
        3'd2:    sel_o = SEL_COUNT;
        3'd3:    sel_o = SEL_LBALO;
        3'd4:    sel_o = SEL_BCLO;
        3'd5:    sel_o = SEL_BCHI;
        3'd6:    sel_o = SEL_DEV;
        default: sel_o = SEL_STATCMD;
      endcase
    end else if (cs0_n && !cs1_n && da == 3'd6) begin
      sel_o = SEL_ALTCTL;
    end
  end
endmodule

// File: rtl/atapi_rp_pktstore.sv
module atapi_rp_pktstore #(
  parameter int PKT_BYTES = 12,
  localparam int IDX_W    = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [15:0]      word_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             ready_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_q, ready_d;
  logic             ovf_q, ovf_d;
  logic             accept;
  logic [PKT_BYTES-1:0][7:0] bytes;

  assign accept = wr_i && !soft_rst_i && !flush_i &&
                  (cnt_q <= CNT_W'(PKT_BYTES - 2));

  for (genvar i = 0; i < PKT_BYTES; i++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    logic       lo_hit, hi_hit;
    assign lo_hit = accept && (cnt_q == CNT_W'(i));
    if (i == 0) begin : g_first
      assign hi_hit = 1'b0;
    end else begin : g_rest
      assign hi_hit = accept && (cnt_q == CNT_W'(i - 1));
    end
    always_comb begin
      lane_d = lane_q;
      if (lo_hit)      lane_d = word_i[7:0];
      else if (hi_hit) lane_d = word_i[15:8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end
    assign bytes[i] = lane_q;
  end

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    ovf_d   = ovf_q;
    if (soft_rst_i) begin
      cnt_d   = '0;
      ready_d = 1'b0;
      ovf_d   = 1'b0;
    end else if (flush_i) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (wr_i) begin
      if (accept) begin
        cnt_d = cnt_q + CNT_W'(2);
        if (cnt_q == CNT_W'(PKT_BYTES - 2)) ready_d = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      ovf_q   <= ovf_d;
    end
  end

  assign byte_o  = (32'(idx_i) < PKT_BYTES) ? bytes[idx_i] : 8'h00;
  assign ready_o = ready_q;
  assign ovf_o   = ovf_q;

  // R4
  pkt_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PKT_BYTES));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !soft_rst_i) |=> ovf_q);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !flush_i && !soft_rst_i) |=> ready_q);
endmodule

// File: rtl/atapi_regport.sv
module atapi_regport
  import atapi_rp_pkg::*;
#(
  parameter int PKT_BYTES = 12,
  parameter int SYNC_STAGES = 2,
  parameter bit DEV_ID = 1'b0,
  localparam int IDX_W = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hrst_n,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic [2:0]       da,
  input  logic             dior_n,
  input  logic             diow_n,
  input  logic [15:0]      dd_i,
  output logic [15:0]      dd_o,
  output logic             dd_oe,
  output logic             iordy,
  output logic             intrq_o,
  output logic             intrq_oe,
  input  logic [7:0]       fw_status,
  input  logic             irq_set,
  input  logic             pkt_phase,
  input  logic             pkt_clear,
  output logic             pkt_ready,
  input  logic [IDX_W-1:0] pkt_idx,
  output logic [7:0]       pkt_byte,
  input  logic             buf_valid,
  input  logic [15:0]      buf_data,
  output logic             buf_pop,
  output logic [7:0]       cmd_code,
  output logic             cmd_stb,
  output logic [7:0]       tf_features,
  output logic [15:0]      tf_bytecnt
);
  // strobe synchronisation and edge detection
  logic [2:0] sync_lvl;
  logic       rd_lvl, wr_lvl, hr_lvl;
  logic       rd_dly_q, wr_dly_q;
  logic       rd_fall, rd_rise, wr_fall;

  atapi_rp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({hrst_n, diow_n, dior_n}),
    .level_o(sync_lvl)
  );
  assign rd_lvl = sync_lvl[0];
  assign wr_lvl = sync_lvl[1];
  assign hr_lvl = sync_lvl[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_dly_q <= 1'b1;
      wr_dly_q <= 1'b1;
    end else begin
      rd_dly_q <= rd_lvl;
      wr_dly_q <= wr_lvl;
    end
  end
  assign rd_fall = rd_dly_q && !rd_lvl;
  assign rd_rise = !rd_dly_q && rd_lvl;
  assign wr_fall = wr_dly_q && !wr_lvl;

  rp_sel_e sel;
  atapi_rp_decode u_dec (.cs0_n(cs0_n), .cs1_n(cs1_n), .da(da), .sel_o(sel));

  // task-file state
  logic [7:0] count_q, count_d, lbalo_q, lbalo_d, bclo_q, bclo_d;
  logic [7:0] bchi_q, bchi_d, dev_q, dev_d, feat_q, feat_d, cmd_q, cmd_d;
  logic       nien_q, nien_d, srst_q, srst_d, cstb_q, cstb_d;
  logic       pend_q, pend_d;
  logic       wait_q, wait_d;
  logic [15:0] dout_q, dout_d;
  logic       doe_q, doe_d;
  logic       clr, wr_ev, rd_ev, pio_rd, take_buf;
  logic       ovf, fifo_wr;
  logic [15:0] rd_val;

  assign clr   = srst_q || !hr_lvl;
  assign wr_ev = wr_fall && !clr;
  assign rd_ev = rd_fall && !clr;
  assign pio_rd = (sel == SEL_DATA) && !pkt_phase;
  assign take_buf = !clr && buf_valid &&
                    ((rd_fall && pio_rd) || (wait_q && !rd_rise));
  assign fifo_wr = wr_ev && (sel == SEL_DATA) && pkt_phase;

  atapi_rp_pktstore #(.PKT_BYTES(PKT_BYTES)) u_pkt (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst_i(clr),
    .flush_i   (pkt_clear),
    .wr_i      (fifo_wr),
    .word_i    (dd_i),
    .idx_i     (pkt_idx),
    .byte_o    (pkt_byte),
    .ready_o   (pkt_ready),
    .ovf_o     (ovf)
  );

  always_comb begin
    case (sel)
      SEL_ERRFEAT:             rd_val = {15'h0, ovf};
      SEL_COUNT:               rd_val = {8'h00, count_q};
      SEL_LBALO:               rd_val = {8'h00, lbalo_q};
      SEL_BCLO:                rd_val = {8'h00, bclo_q};
      SEL_BCHI:                rd_val = {8'h00, bchi_q};
      SEL_DEV:                 rd_val = {8'h00, dev_q};
      SEL_STATCMD, SEL_ALTCTL: rd_val = {8'h00, fw_status};
      default:                 rd_val = 16'h0000;
    endcase
  end

  // register write path
  always_comb begin
    count_d = count_q; lbalo_d = lbalo_q; bclo_d = bclo_q; bchi_d = bchi_q;
    dev_d = dev_q; feat_d = feat_q; cmd_d = cmd_q;
    nien_d = nien_q; srst_d = srst_q; cstb_d = 1'b0;
    if (clr) begin
      count_d = '0; lbalo_d = '0; bclo_d = '0; bchi_d = '0;
      dev_d = '0; feat_d = '0; cmd_d = '0; nien_d = 1'b0; srst_d = 1'b0;
    end else if (wr_ev) begin
      case (sel)
        SEL_ERRFEAT: feat_d  = dd_i[7:0];
        SEL_COUNT:   count_d = dd_i[7:0];
        SEL_LBALO:   lbalo_d = dd_i[7:0];
        SEL_BCLO:    bclo_d  = dd_i[7:0];
        SEL_BCHI:    bchi_d  = dd_i[7:0];
        SEL_DEV:     dev_d   = dd_i[7:0];
        SEL_STATCMD: begin
          cmd_d  = dd_i[7:0];
          cstb_d = 1'b1;
        end
        SEL_ALTCTL: begin
          nien_d = dd_i[CTL_NIEN_BIT];
          srst_d = dd_i[CTL_SRST_BIT];
        end
        default: ;
      endcase
    end
  end

  // interrupt pending, read path and ready stall
  always_comb begin
    pend_d = pend_q;
    if (clr)                              pend_d = 1'b0;
    else if (irq_set)                     pend_d = 1'b1;
    else if (rd_ev && sel == SEL_STATCMD) pend_d = 1'b0;
  end

  always_comb begin
    wait_d = wait_q;
    dout_d = dout_q;
    doe_d  = doe_q;
    if (clr) begin
      wait_d = 1'b0;
      doe_d  = 1'b0;
    end else if (take_buf) begin
      wait_d = 1'b0;
      dout_d = buf_data;
      doe_d  = 1'b1;
    end else if (rd_rise) begin
      wait_d = 1'b0;
      doe_d  = 1'b0;
    end else if (rd_fall && pio_rd) begin
      wait_d = 1'b1;
    end else if (rd_fall && sel != SEL_NONE) begin
      dout_d = rd_val;
      doe_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0; lbalo_q <= '0; bclo_q <= '0; bchi_q <= '0;
      dev_q <= '0; feat_q <= '0; cmd_q <= '0;
      nien_q <= 1'b0; srst_q <= 1'b0; cstb_q <= 1'b0; pend_q <= 1'b0;
      wait_q <= 1'b0; dout_q <= '0; doe_q <= 1'b0;
    end else begin
      count_q <= count_d; lbalo_q <= lbalo_d; bclo_q <= bclo_d;
      bchi_q <= bchi_d; dev_q <= dev_d; feat_q <= feat_d; cmd_q <= cmd_d;
      nien_q <= nien_d; srst_q <= srst_d; cstb_q <= cstb_d; pend_q <= pend_d;
      wait_q <= wait_d; dout_q <= dout_d; doe_q <= doe_d;
    end
  end

  assign dd_o        = dout_q;
  assign dd_oe       = doe_q;
  assign iordy       = !wait_q;
  assign buf_pop     = take_buf;
  assign intrq_o     = pend_q;
  assign intrq_oe    = !nien_q && (dev_q[DEV_SEL_BIT] == DEV_ID);
  assign cmd_code    = cmd_q;
  assign cmd_stb     = cstb_q;
  assign tf_features = feat_q;
  assign tf_bytecnt  = {bchi_q, bclo_q};

  // R3
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |=> !buf_pop);

  // R8
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iordy && rd_rise) |=> iordy);

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && sel == SEL_STATCMD && !irq_set) |=> !intrq_o);

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pkt_ready && !intrq_o && iordy));
endmodule

// File: tb/atapi_regport_tb_top.sv
module atapi_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, hrst_n = 1'b1;
  logic cs0_n = 1'b1, cs1_n = 1'b1, dior_n = 1'b1, diow_n = 1'b1;
  logic [2:0] da = '0;
  logic [15:0] dd_i = '0, dd_o;
  logic dd_oe, iordy, intrq_o, intrq_oe;
  logic [7:0] fw_status = 8'h58;
  logic irq_set = 1'b0, pkt_phase = 1'b0, pkt_clear = 1'b0, pkt_ready;
  logic [3:0] pkt_idx = '0;
  logic [7:0] pkt_byte, cmd_code, tf_features;
  logic buf_valid = 1'b0, buf_pop, cmd_stb;
  logic [15:0] buf_data = '0, tf_bytecnt;

  always #4 clk = ~clk;

  atapi_regport dut_i (.*);

  int checks = 0, errors = 0, stb_cnt = 0, cyc = 0;
  logic [15:0] bq[$];
  logic [15:0] eq[$];
  logic [7:0] mq[$];
  logic [7:0] m_cnt, m_lba, m_bclo, m_bchi, m_dev, m_cmd;
  bit m_nien, m_pend, m_ovf, m_ready;
  bit pop_seen = 1'b0;

  always @(posedge clk) pop_seen <= buf_pop;
  always @(negedge clk) begin
    if (pop_seen && bq.size() != 0) void'(bq.pop_front());
    buf_valid = (bq.size() != 0);
    buf_data  = (bq.size() != 0) ? bq[0] : 16'h0;
    if (cmd_stb) stb_cnt++;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void model_reset();
    m_cnt = 0; m_lba = 0; m_bclo = 0; m_bchi = 0; m_dev = 0; m_cmd = 0;
    m_nien = 0; m_pend = 0; m_ovf = 0; m_ready = 0;
    mq.delete();
  endfunction

  function automatic void model_write(bit c0, bit c1, logic [2:0] a, logic [15:0] d);
    if (!c0 && c1) begin
      case (a)
        3'd0: if (pkt_phase) begin
                if (mq.size() >= 12) m_ovf = 1;
                else begin
                  mq.push_back(d[7:0]); mq.push_back(d[15:8]);
                  if (mq.size() == 12) m_ready = 1;
                end
              end
        3'd2: m_cnt = d[7:0];
        3'd3: m_lba = d[7:0];
        3'd4: m_bclo = d[7:0];
        3'd5: m_bchi = d[7:0];
        3'd6: m_dev = d[7:0];
        3'd7: m_cmd = d[7:0];
        default: ;
      endcase
    end else if (c0 && !c1 && a == 3'd6) begin
      if (d[2]) model_reset();
      else m_nien = d[1];
    end
  endfunction

  task automatic hwrite(bit c0, bit c1, logic [2:0] a, logic [15:0] d);
    @(negedge clk); cs0_n = c0; cs1_n = c1; da = a; dd_i = d;
    @(negedge clk); diow_n = 1'b0;
    idle(4); diow_n = 1'b1; idle(4);
    model_write(c0, c1, a, d);
  endtask

  task automatic hread(bit c0, bit c1, logic [2:0] a, int hold,
                       output logic [15:0] d, output logic oe);
    int guard = 0;
    @(negedge clk); cs0_n = c0; cs1_n = c1; da = a;
    @(negedge clk); dior_n = 1'b0;
    idle(hold);
    while (iordy == 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    d = dd_o; oe = dd_oe;
    dior_n = 1'b1; idle(4);
  endtask

  task automatic state_chk(string req);
    chk(pkt_ready == m_ready, req, pkt_ready, m_ready);
    chk(intrq_o == m_pend, req, intrq_o, m_pend);
    chk(intrq_oe == (!m_nien && m_dev[4] == 1'b0), req, intrq_oe, !m_nien);
  endtask

  task automatic reg_chk(logic [2:0] a, logic [7:0] exp, string req);
    logic [15:0] d; logic oe;
    hread(1'b0, 1'b1, a, 4, d, oe);
    chk(oe && d == {8'h00, exp}, req, d, exp);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog actual %0d expected done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d; logic oe; int s0;
    model_reset();
    idle(3); rst_n = 1'b1; idle(4);
    // reset state (R9 values)
    chk(iordy && !dd_oe && !buf_pop, "R9 reset", {iordy, dd_oe}, 2'b10);
    state_chk("R6 reset");

    // R2 register readback, 8-bit only
    hwrite(0, 1, 3'd3, 16'hA55A); reg_chk(3'd3, 8'h5A, "R2 lba");
    hwrite(0, 1, 3'd4, 16'h0034); hwrite(0, 1, 3'd5, 16'h0012);
    chk(tf_bytecnt == 16'h1234, "R2 bytecnt", tf_bytecnt, 16'h1234);
    reg_chk(3'd5, 8'h12, "R2 bchi");
    hwrite(0, 1, 3'd2, 16'h00C3); reg_chk(3'd2, 8'hC3, "R2 count");
    hwrite(0, 1, 3'd1, 16'h0077);
    chk(tf_features == 8'h77, "R2 features", tf_features, 8'h77);

    // R1 decode: alt status and unselected
    hread(1, 0, 3'd6, 4, d, oe);
    chk(oe && d == 16'h0058, "R1 altstatus", d, 16'h0058);
    hread(1, 1, 3'd3, 4, d, oe);
    chk(!oe, "R1 no select", oe, 0);
    hwrite(1, 1, 3'd3, 16'h0099); reg_chk(3'd3, 8'h5A, "R1 write ignored");

    // R10 command
    s0 = stb_cnt;
    hwrite(0, 1, 3'd7, 16'h00A0);
    chk(cmd_code == 8'hA0 && stb_cnt == s0 + 1, "R10 cmd", {cmd_code, 8'(stb_cnt - s0)}, 16'hA001);

    // R11 writes outside packet phase ignored, then R4 packet fill
    pkt_phase = 1'b0;
    hwrite(0, 1, 3'd0, 16'hDEAD); hwrite(0, 1, 3'd0, 16'hBEEF);
    pkt_phase = 1'b1;
    for (int k = 0; k < 5; k++) hwrite(0, 1, 3'd0, 16'h0100 * (2 * k + 1) + 16'(2 * k));
    chk(!pkt_ready, "R11 not full after 5", pkt_ready, 0);
    hwrite(0, 1, 3'd0, 16'h0B0A);
    state_chk("R4 ready");
    for (int k = 0; k < 12; k++) begin
      pkt_idx = 4'(k); #1;
      chk(pkt_byte == mq[k], "R4 byte order", pkt_byte, mq[k]);
    end
    // R5 overflow
    hwrite(0, 1, 3'd0, 16'hFFEE);
    pkt_idx = 4'd11; #1;
    chk(pkt_byte == 8'h0B, "R5 ignored", pkt_byte, 8'h0B);
    reg_chk(3'd1, 8'h01, "R5 error bit");
    @(negedge clk); pkt_clear = 1'b1; @(negedge clk); pkt_clear = 1'b0;
    m_ready = 0; mq.delete(); idle(1);
    state_chk("R4 clear");
    reg_chk(3'd1, 8'h01, "R5 sticky after clear");
    pkt_phase = 1'b0;

    // R7 / R6 interrupts
    @(negedge clk); irq_set = 1'b1; @(negedge clk); irq_set = 1'b0; m_pend = 1; idle(1);
    state_chk("R7 set");
    hread(1, 0, 3'd6, 4, d, oe); state_chk("R7 alt keeps");
    hread(0, 1, 3'd7, 4, d, oe); m_pend = 0; state_chk("R7 status clears");
    hwrite(1, 0, 3'd6, 16'h0002); state_chk("R6 nien");
    hwrite(1, 0, 3'd6, 16'h0000); hwrite(0, 1, 3'd6, 16'h0010);
    chk(!intrq_oe, "R6 other device", intrq_oe, 0);
    hwrite(0, 1, 3'd6, 16'h00E0); state_chk("R6 selected");

    // R8 PIO reads
    bq.push_back(16'h1111); bq.push_back(16'h2222); bq.push_back(16'h3333);
    eq.push_back(16'h1111); eq.push_back(16'h2222); eq.push_back(16'h3333);
    idle(2);
    hread(0, 1, 3'd0, 4, d, oe);
    chk(oe && d == eq[0], "R8 first word", d, eq[0]); void'(eq.pop_front());
    hread(0, 1, 3'd0, 20, d, oe);
    chk(d == eq[0], "R3 long strobe", d, eq[0]); void'(eq.pop_front());
    hread(0, 1, 3'd0, 4, d, oe);
    chk(d == eq[0], "R3 one pop per strobe", d, eq[0]); void'(eq.pop_front());
    idle(2);
    fork
      begin hread(0, 1, 3'd0, 4, d, oe); end
      begin
        idle(14);
        chk(!iordy, "R8 stall", iordy, 0);
        bq.push_back(16'hBEEF);
      end
    join
    chk(oe && d == 16'hBEEF && iordy, "R8 stall release", d, 16'hBEEF);

    // R9 soft reset
    pkt_phase = 1'b1; hwrite(0, 1, 3'd0, 16'h4321); pkt_phase = 1'b0;
    @(negedge clk); irq_set = 1'b1; @(negedge clk); irq_set = 1'b0; m_pend = 1;
    hwrite(1, 0, 3'd6, 16'h0006);
    state_chk("R9 soft");
    reg_chk(3'd3, 8'h00, "R9 soft lba");
    reg_chk(3'd1, 8'h00, "R9 soft ovf");
    chk(tf_bytecnt == 16'h0 && cmd_code == 8'h0, "R9 soft tf", tf_bytecnt, 0);
    // R9 hardware reset
    hwrite(0, 1, 3'd5, 16'h0066);
    @(negedge clk); hrst_n = 1'b0; idle(5); hrst_n = 1'b1; idle(5);
    model_reset();
    reg_chk(3'd5, 8'h00, "R9 hard bchi");
    state_chk("R9 hard");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule